// File: doc/BRIEF.md
# Warp Instruction Issue Router

This block is the routing half of a per-scheduler issue stage in a SIMT core. In each cycle it looks at the one or two instructions at the head of the selected warp's instruction buffer. It classifies each opcode class and sends the instruction to one of six execution pipeline input registers: single-precision (SP), integer (INT), double-precision (DP), special-function (SFU), tensor, or memory (MEM). Scoreboard checks, divergence-stack handling and the execution units themselves sit outside the block. The block only decides where each instruction goes and in which slot of the destination pipeline register it lands.

Routing follows configuration straps. The INT pipe is used only when integer units exist. DP work goes to the SFU when no DP units exist. An optional different-unit mode stops two instructions of the same cycle from going to the same unit type. A sub-core mode gives every scheduler a dedicated slot in each pipeline register. Outside that mode, the lowest free slot is taken.

The decision for a cycle is registered. The strobes, slot indices, warp id, scheduler id and the count of consumed buffer entries therefore appear one clock after the inputs that produced them. Later stages use the warp id and scheduler id to select register banks.

Top module: `wir_issue_router`

## Requirements
- R1: Opcode classes load (6), store (7), memory barrier (8), tensor load (9) and tensor store (10) issue only to the MEM pipe (strobe bit 5), and only when that pipe offers a usable free slot.
- R2: Class ALU (0) issues to INT (bit 1) when the INT-present strap is set, and to SP (bit 0) otherwise. Class SP-float (1) always issues to SP. An ALU op never falls back to SP when INT is present but busy.
- R3: Class DP (2) issues to DP (bit 2) when the DP-present strap is set, and to SFU (bit 3) otherwise. Classes SFU (3) and ALU-SFU (4) issue to SFU. A DP op with DP present but the DP pipe busy does not issue.
- R4: Class tensor (5) issues only to the tensor pipe (bit 4).
- R5: With the different-unit strap set, an instruction may not go to the unit type used by the instruction issued just before it in the same cycle. A tensor op after an SP issue is also blocked. With the strap clear, SP followed by tensor issues both.
- R6: Issue proceeds in buffer order: entry k is tried only if the warp is not waiting, entry k is valid, and entries 0..k-1 all issued. The first entry that cannot issue ends the cycle. At most MAX_ISSUE entries are consumed.
- R7: In sub-core mode, a pipe is usable only if its slot indexed by the scheduler id is free, and the issued slot index equals the scheduler id.
- R8: Outside sub-core mode, a pipe is usable if any slot is free, and the issued slot index is the lowest free one.
- R9: Each issued instruction raises exactly one pipe strobe, and no pipe is strobed twice in a cycle. Outputs appear one clock after the inputs. Each strobed pipe carries the warp id, the scheduler id and the buffer position (0 or 1), and the pop count equals the number of strobes.
- R10: While reset is asserted, all strobes, pop count, slot, warp id and scheduler id outputs are zero.
- R11: Class codes 11 to 15 never issue and end the cycle at that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_int_en | input | 1 | Integer units present |
| cfg_dp_en | input | 1 | DP units present |
| cfg_diff_unit | input | 1 | Different-unit issue mode |
| cfg_subcore | input | 1 | Sub-core slot ownership mode |
| sched_id | input | SIDW (2) | Scheduler id of this issue stage |
| warp_id | input | WID_W (6) | Warp selected this cycle |
| warp_wait | input | 1 | Warp is waiting; nothing may issue |
| ib_valid | input | MAX_ISSUE (2) | Valid flags of buffer entries 0..MAX_ISSUE-1 |
| ib_cls | input | 4*MAX_ISSUE (8) | Opcode class per entry, entry k at bits 4k+3:4k |
| pipe_free | input | 6*NSCHED (24) | Free slot flags, pipe p at bits p*NSCHED+NSCHED-1:p*NSCHED |
| iss_vld | output | 6 | Issue strobe per pipe (0 SP, 1 INT, 2 DP, 3 SFU, 4 tensor, 5 MEM) |
| iss_pos | output | 6*POSW (6) | Buffer position of the instruction sent to each pipe |
| iss_slot | output | 6*SIDW (12) | Slot index allocated in each pipe |
| iss_wid | output | 6*WID_W (36) | Warp id carried on each pipe |
| iss_sid | output | 6*SIDW (12) | Scheduler id carried on each pipe |
| ib_pop | output | CNTW (2) | Number of buffer entries consumed |

## Verification
The hardest situation to reach is a second instruction that is legal on its own but blocked by what the first one did in the same cycle. Examples are a tensor op behind an SP op in different-unit mode, or a second op aimed at a pipe the first one already took. A second case is a pipe that has free slots, but not the one owned by this scheduler. The table drives paired buffer entries under each strap combination, with pipe-free masks that leave only chosen slots open. This makes the second entry's fate, and the slot picked, depend on exactly one rule.

// File: rtl/wir_pkg.sv
package wir_pkg;

  localparam int NPIPE = 6;
  localparam int CLS_W = 4;

  typedef enum logic [2:0] {
    P_SP   = 3'd0,
    P_INT  = 3'd1,
    P_DP   = 3'd2,
    P_SFU  = 3'd3,
    P_TNS  = 3'd4,
    P_MEM  = 3'd5,
    P_NONE = 3'd7
  } pipe_e;

  localparam logic [CLS_W-1:0] C_ALU  = 4'd0;
  localparam logic [CLS_W-1:0] C_SPF  = 4'd1;
  localparam logic [CLS_W-1:0] C_DPF  = 4'd2;
  localparam logic [CLS_W-1:0] C_SFU  = 4'd3;
  localparam logic [CLS_W-1:0] C_ASFU = 4'd4;
  localparam logic [CLS_W-1:0] C_TNS  = 4'd5;
  localparam logic [CLS_W-1:0] C_LD   = 4'd6;
  localparam logic [CLS_W-1:0] C_ST   = 4'd7;
  localparam logic [CLS_W-1:0] C_MBAR = 4'd8;
  localparam logic [CLS_W-1:0] C_TLD  = 4'd9;
  localparam logic [CLS_W-1:0] C_TST  = 4'd10;

  // Memory-side opcode classes.
  function automatic logic is_mem_cls(input logic [CLS_W-1:0] cls);
    return (cls == C_LD) || (cls == C_ST) || (cls == C_MBAR) ||
           (cls == C_TLD) || (cls == C_TST);
  endfunction

  // Target pipe of a class under the unit-presence straps.
  function automatic pipe_e route_target(input logic [CLS_W-1:0] cls,
                                         input logic int_en,
                                         input logic dp_en);
    pipe_e t;
    case (cls)
      C_ALU:               t = int_en ? P_INT : P_SP;
      C_SPF:               t = P_SP;
      C_DPF:               t = dp_en ? P_DP : P_SFU;
      C_SFU, C_ASFU:       t = P_SFU;
      C_TNS:               t = P_TNS;
      C_LD, C_ST, C_MBAR,
      C_TLD, C_TST:        t = P_MEM;
      default:             t = P_NONE;
    endcase
    return t;
  endfunction

  // Different-unit rule: same type blocked, tensor after SP blocked.
  function automatic logic diff_blocks(input pipe_e tgt, input pipe_e prev);
    return (prev != P_NONE) && ((tgt == prev) || (tgt == P_TNS && prev == P_SP));
  endfunction

endpackage

// File: rtl/wir_slot_pick.sv
module wir_slot_pick #(
  parameter int NSCHED = 4,
  localparam int SIDW = (NSCHED > 1) ? $clog2(NSCHED) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_subcore,
  input  logic [SIDW-1:0]   sched_id,
  input  logic [NSCHED-1:0] free_i,
  output logic              avail_o,
  output logic [SIDW-1:0]   slot_o
);

  logic [SIDW-1:0] low_slot;
  logic            any_free;

  // Lowest free slot, scanned from the top down.
  always_comb begin
    low_slot = '0;
    any_free = 1'b0;
    for (int s = NSCHED - 1; s >= 0; s--) begin
      if (free_i[s]) begin
        low_slot = SIDW'(s);
        any_free = 1'b1;
      end
    end
  end

  assign avail_o = cfg_subcore ? free_i[sched_id] : any_free;
  assign slot_o  = cfg_subcore ? sched_id : low_slot;

  AST_SLOT_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    avail_o |-> free_i[slot_o]);                                          // R7
  AST_LOWEST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_subcore && avail_o) |->
      ((free_i & ((NSCHED'(1) << slot_o) - NSCHED'(1))) == '0));          // R8

endmodule

// File: rtl/wir_route_step.sv
module wir_route_step
  import wir_pkg::*;
(
  input  logic             int_en,
  input  logic             dp_en,
  input  logic             diff_en,
  input  logic [CLS_W-1:0] cls_i,
  input  logic             vld_i,
  input  logic             go_i,
  input  logic [NPIPE-1:0] avail_i,
  input  logic [NPIPE-1:0] taken_i,
  input  pipe_e            prev_i,
  output logic [NPIPE-1:0] sel_o,
  output logic             go_o,
  output logic [NPIPE-1:0] taken_o,
  output pipe_e            prev_o
);

  pipe_e      tgt;
  logic [7:0] av_pad;
  logic [7:0] tk_pad;
  logic [7:0] one_hot;
  logic       ok;

  assign tgt     = route_target(cls_i, int_en, dp_en);
  assign av_pad  = {{(8-NPIPE){1'b0}}, avail_i};
  assign tk_pad  = {{(8-NPIPE){1'b0}}, taken_i};
  assign one_hot = 8'd1 << tgt;

  assign ok = go_i && vld_i && (tgt != P_NONE) && av_pad[tgt] && !tk_pad[tgt] &&
              !(diff_en && diff_blocks(tgt, prev_i));

  assign sel_o   = ok ? one_hot[NPIPE-1:0] : '0;
  assign go_o    = ok;
  assign taken_o = taken_i | sel_o;
  assign prev_o  = ok ? tgt : prev_i;

endmodule

// File: rtl/wir_issue_router.sv
module wir_issue_router
  import wir_pkg::*;
#(
  parameter int NSCHED    = 4,
  parameter int WID_W     = 6,
  parameter int MAX_ISSUE = 2,
  localparam int SIDW = (NSCHED > 1) ? $clog2(NSCHED) : 1,
  localparam int POSW = (MAX_ISSUE > 1) ? $clog2(MAX_ISSUE) : 1,
  localparam int CNTW = $clog2(MAX_ISSUE + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_int_en,
  input  logic                      cfg_dp_en,
  input  logic                      cfg_diff_unit,
  input  logic                      cfg_subcore,
  input  logic [SIDW-1:0]           sched_id,
  input  logic [WID_W-1:0]          warp_id,
  input  logic                      warp_wait,
  input  logic [MAX_ISSUE-1:0]      ib_valid,
  input  logic [CLS_W*MAX_ISSUE-1:0] ib_cls,
  input  logic [NPIPE*NSCHED-1:0]   pipe_free,
  output logic [NPIPE-1:0]          iss_vld,
  output logic [NPIPE*POSW-1:0]     iss_pos,
  output logic [NPIPE*SIDW-1:0]     iss_slot,
  output logic [NPIPE*WID_W-1:0]    iss_wid,
  output logic [NPIPE*SIDW-1:0]     iss_sid,
  output logic [CNTW-1:0]           ib_pop
);

  // Per-pipe slot availability.
  logic [NPIPE-1:0] avail_w;
  logic [SIDW-1:0]  slot_w [NPIPE];

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    wir_slot_pick #(.NSCHED(NSCHED)) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_subcore(cfg_subcore),
      .sched_id   (sched_id),
      .free_i     (pipe_free[p*NSCHED +: NSCHED]),
      .avail_o    (avail_w[p]),
      .slot_o     (slot_w[p])
    );
  end

  // In-order issue chain across buffer entries.
  logic [NPIPE-1:0] sel   [MAX_ISSUE];
  logic             go    [MAX_ISSUE+1];
  logic [NPIPE-1:0] taken [MAX_ISSUE+1];
  pipe_e            prev  [MAX_ISSUE+1];

  assign go[0]    = !warp_wait;
  assign taken[0] = '0;
  assign prev[0]  = P_NONE;

  for (genvar k = 0; k < MAX_ISSUE; k++) begin : g_step
    wir_route_step u_step (
      .int_en (cfg_int_en),
      .dp_en  (cfg_dp_en),
      .diff_en(cfg_diff_unit),
      .cls_i  (ib_cls[k*CLS_W +: CLS_W]),
      .vld_i  (ib_valid[k]),
      .go_i   (go[k]),
      .avail_i(avail_w),
      .taken_i(taken[k]),
      .prev_i (prev[k]),
      .sel_o  (sel[k]),
      .go_o   (go[k+1]),
      .taken_o(taken[k+1]),
      .prev_o (prev[k+1])
    );

    AST_ONE_PIPE_PER_INST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel[k]));                                                  // R9
    AST_MEM_ONLY_MEMCLS: assert property (@(posedge clk) disable iff (!rst_n)
      sel[k][P_MEM] |-> is_mem_cls(ib_cls[k*CLS_W +: CLS_W]));            // R1
    AST_INT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      sel[k][P_INT] |-> (cfg_int_en && ib_cls[k*CLS_W +: CLS_W] == C_ALU)); // R2
    AST_DP_NEEDS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      sel[k][P_DP] |-> cfg_dp_en);                                        // R3
    AST_TNS_ONLY_TNSCLS: assert property (@(posedge clk) disable iff (!rst_n)
      sel[k][P_TNS] |-> (ib_cls[k*CLS_W +: CLS_W] == C_TNS));             // R4

    if (k > 0) begin : g_pair
      AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (|sel[k]) |-> (|sel[k-1]));                                       // R6
      AST_NO_PIPE_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[k] & sel[k-1]) == '0);                                       // R9
      AST_DIFF_TNS_AFTER_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_diff_unit && sel[k][P_TNS]) |-> !sel[k-1][P_SP]);            // R5
    end
  end

  // Merge the chain into per-pipe next values.
  logic [NPIPE-1:0]      nxt_vld;
  logic [NPIPE*POSW-1:0] nxt_pos;
  logic [CNTW-1:0]       nxt_cnt;

  always_comb begin
    nxt_vld = '0;
    nxt_pos = '0;
    nxt_cnt = '0;
    for (int k = 0; k < MAX_ISSUE; k++) begin
      nxt_vld = nxt_vld | sel[k];
      for (int p = 0; p < NPIPE; p++) begin
        if (sel[k][p]) nxt_pos[p*POSW +: POSW] = POSW'(k);
      end
      if (|sel[k]) nxt_cnt = nxt_cnt + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_vld  <= '0;
      iss_pos  <= '0;
      iss_slot <= '0;
      iss_wid  <= '0;
      iss_sid  <= '0;
      ib_pop   <= '0;
    end else begin
      iss_vld <= nxt_vld;
      iss_pos <= nxt_pos;
      ib_pop  <= nxt_cnt;
      for (int p = 0; p < NPIPE; p++) begin
        iss_slot[p*SIDW +: SIDW]   <= nxt_vld[p] ? slot_w[p] : '0;
        iss_wid[p*WID_W +: WID_W]  <= nxt_vld[p] ? warp_id   : '0;
        iss_sid[p*SIDW +: SIDW]    <= nxt_vld[p] ? sched_id  : '0;
      end
    end
  end

  AST_POP_MATCHES_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_vld) == int'(ib_pop));                                 // R9
  AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    warp_wait |=> (iss_vld == '0));                                       // R6

endmodule

// File: tb/wir_issue_router_tb_top.sv
`timescale 1ns/1ps
module wir_issue_router_tb_top;

  localparam int NV = 22;
  // {cfg{int,dp,diff,sub}, wait, valid[1:0], cls0, cls1, free[23:0], sid, exp_vld, exp_pos, exp_pop}
  localparam logic [54:0] TV [NV] = '{
    {4'b1100,1'b0,2'b11,4'h0,4'h1,24'hFFFFFF,2'd0,6'b000011,6'b000001,2'd2},
    {4'b0100,1'b0,2'b11,4'h0,4'h1,24'hFFFFFF,2'd0,6'b000001,6'b000000,2'd1},
    {4'b0000,1'b0,2'b11,4'h2,4'h3,24'hFFFFFF,2'd0,6'b001000,6'b000000,2'd1},
    {4'b0100,1'b0,2'b11,4'h2,4'h4,24'hFFFFFF,2'd0,6'b001100,6'b001000,2'd2},
    {4'b1100,1'b0,2'b11,4'h6,4'h5,24'hFFFFFF,2'd0,6'b110000,6'b010000,2'd2},
    {4'b1110,1'b0,2'b11,4'h1,4'h5,24'hFFFFFF,2'd0,6'b000001,6'b000000,2'd1},
    {4'b1100,1'b0,2'b11,4'h1,4'h5,24'hFFFFFF,2'd0,6'b010001,6'b010000,2'd2},
    {4'b1100,1'b0,2'b11,4'h7,4'h0,24'h0FFFFF,2'd0,6'b000000,6'b000000,2'd0},
    {4'b1100,1'b1,2'b11,4'h0,4'h1,24'hFFFFFF,2'd0,6'b000000,6'b000000,2'd0},
    {4'b1100,1'b0,2'b01,4'h0,4'h1,24'hFFFFFF,2'd0,6'b000010,6'b000000,2'd1},
    {4'b1100,1'b0,2'b10,4'h0,4'h1,24'hFFFFFF,2'd0,6'b000000,6'b000000,2'd0},
    {4'b1100,1'b0,2'b11,4'hC,4'h0,24'hFFFFFF,2'd0,6'b000000,6'b000000,2'd0},
    {4'b1100,1'b0,2'b11,4'h8,4'h9,24'hFFFFFF,2'd0,6'b100000,6'b000000,2'd1},
    {4'b1100,1'b0,2'b11,4'h5,4'hA,24'hFFFFFF,2'd0,6'b110000,6'b100000,2'd2},
    {4'b1100,1'b0,2'b11,4'h0,4'h0,24'hFFFFFF,2'd0,6'b000010,6'b000000,2'd1},
    {4'b1101,1'b0,2'b11,4'h0,4'h1,24'hFFFF2F,2'd2,6'b000000,6'b000000,2'd0},
    {4'b1100,1'b0,2'b11,4'h0,4'h1,24'hFFFF2F,2'd2,6'b000011,6'b000001,2'd2},
    {4'b1100,1'b0,2'b11,4'h2,4'h3,24'hFFF0FF,2'd0,6'b000000,6'b000000,2'd0},
    {4'b0110,1'b0,2'b11,4'h2,4'h4,24'hFFFFFF,2'd0,6'b001100,6'b001000,2'd2},
    {4'b1100,1'b0,2'b11,4'h0,4'h1,24'hFFFF0F,2'd0,6'b000000,6'b000000,2'd0},
    {4'b1100,1'b0,2'b11,4'h3,4'hF,24'hFFFFFF,2'd1,6'b001000,6'b000000,2'd1},
    {4'b1101,1'b0,2'b11,4'h9,4'h1,24'hFFFFFF,2'd3,6'b100001,6'b000001,2'd2}
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1, 19:      return "R2";
      2, 3, 17:      return "R3";
      4:             return "R4";
      5, 6, 18:      return "R5";
      7, 13:         return "R1";
      8, 9, 10:      return "R6";
      11, 20:        return "R11";
      12, 14:        return "R9";
      15, 21:        return "R7";
      default:       return "R8";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_int_en = 1'b0, cfg_dp_en = 1'b0, cfg_diff_unit = 1'b0, cfg_subcore = 1'b0;
  logic [1:0]  sched_id = '0;
  logic [5:0]  warp_id = 6'd13;
  logic        warp_wait = 1'b0;
  logic [1:0]  ib_valid = '0;
  logic [7:0]  ib_cls = '0;
  logic [23:0] pipe_free = '0;
  logic [5:0]  iss_vld;
  logic [5:0]  iss_pos;
  logic [11:0] iss_slot;
  logic [35:0] iss_wid;
  logic [11:0] iss_sid;
  logic [1:0]  ib_pop;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wir_issue_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_int_en(cfg_int_en), .cfg_dp_en(cfg_dp_en),
    .cfg_diff_unit(cfg_diff_unit), .cfg_subcore(cfg_subcore),
    .sched_id(sched_id), .warp_id(warp_id), .warp_wait(warp_wait),
    .ib_valid(ib_valid), .ib_cls(ib_cls), .pipe_free(pipe_free),
    .iss_vld(iss_vld), .iss_pos(iss_pos), .iss_slot(iss_slot),
    .iss_wid(iss_wid), .iss_sid(iss_sid), .ib_pop(ib_pop)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] cfg, input logic wt, input logic [1:0] v,
                       input logic [3:0] c0, input logic [3:0] c1,
                       input logic [23:0] fr, input logic [1:0] sid);
    {cfg_int_en, cfg_dp_en, cfg_diff_unit, cfg_subcore} = cfg;
    warp_wait = wt;
    ib_valid  = v;
    ib_cls    = {c1, c0};
    pipe_free = fr;
    sched_id  = sid;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    drive(4'b1100, 1'b0, 2'b11, 4'h0, 4'h1, 24'hFFFFFF, 2'd0);
    repeat (3) @(negedge clk);
    // R10: reset state with issuing inputs present
    check("R10", "vld in reset", int'(iss_vld), 0);
    check("R10", "pop in reset", int'(ib_pop), 0);
    check("R10", "wid in reset", int'(iss_wid != '0), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      v = TV[i];
      @(negedge clk);
      drive(v[54:51], v[50], v[49:48], v[47:44], v[43:40], v[39:16], v[15:14]);
      @(negedge clk);
      check(req_of(i), $sformatf("vec%0d strobes", i), int'(iss_vld), int'(v[13:8]));
      check(req_of(i), $sformatf("vec%0d positions", i), int'(iss_pos & v[13:8]), int'(v[7:2]));
      check(req_of(i), $sformatf("vec%0d pop", i), int'(ib_pop), int'(v[1:0]));
      for (int p = 0; p < 6; p++) begin
        if (v[8+p]) begin
          // R9: id fields carried on every strobed pipe
          check("R9", $sformatf("vec%0d wid pipe%0d", i, p), int'(iss_wid[p*6 +: 6]), 13);
          check("R9", $sformatf("vec%0d sid pipe%0d", i, p), int'(iss_sid[p*2 +: 2]), int'(v[15:14]));
        end
      end
    end

    // R7: sub-core slot equals scheduler id
    @(negedge clk);
    drive(4'b1101, 1'b0, 2'b01, 4'h0, 4'h0, 24'hFFFFFF, 2'd3);
    @(negedge clk);
    check("R7", "subcore INT strobe", int'(iss_vld), 6'b000010);
    check("R7", "subcore INT slot", int'(iss_slot[2 +: 2]), 3);

    // R8: lowest free slot, INT nibble 0110 -> slot 1
    drive(4'b1100, 1'b0, 2'b01, 4'h0, 4'h0, 24'hFFFF6F, 2'd0);
    @(negedge clk);
    check("R8", "lowest slot 0110", int'(iss_slot[2 +: 2]), 1);

    // R8: INT nibble 1000 -> slot 3
    drive(4'b1100, 1'b0, 2'b01, 4'h0, 4'h0, 24'hFFFF8F, 2'd0);
    @(negedge clk);
    check("R8", "lowest slot 1000", int'(iss_slot[2 +: 2]), 3);

    // R10: reset asserted mid-run clears outputs
    drive(4'b1100, 1'b0, 2'b11, 4'h0, 4'h1, 24'hFFFFFF, 2'd0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", "vld after mid reset", int'(iss_vld), 0);
    check("R10", "pop after mid reset", int'(ib_pop), 0);
    @(negedge clk);
    check("R10", "vld held in reset", int'(iss_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "issue resumes", int'(iss_vld), 6'b000011);

    finish_run();
  end

endmodule